// File: doc/BRIEF.md
# Dual-Bank Sample Window Buffer with Overlap Margin

This block sits between a sample producer and a block-processing consumer such as a FIR engine. It has two storage banks, ping and pong. The producer streams one window of samples into one bank while the consumer reads the other bank. The roles swap at each hand-off. Every window the consumer sees starts with a margin: the last `TAPS-1` samples of the window before it. A filter can therefore rebuild its delay line before it processes new data.

Each side takes ownership of a bank through an explicit acquire and release. Acquiring a bank costs one handshake per window. A larger `WINDOW` spreads that fixed cost over more samples. The producer writes one sample per cycle through a valid/ready stream. The consumer reads 256-bit words. Each word packs several consecutive samples, and the lowest sample index sits in the least significant bits.

Top module: `pingpong_window_buf`

## Requirements
- R1: After reset, neither side holds a bank, `in_ready` is low and `rd_data` is zero.
- R2: A producer acquire is granted only when the producer's bank in turn is free. `prod_held` then goes high on the next cycle.
- R3: `in_ready` is high only while the producer holds a bank and fewer than `WINDOW` samples have been written to it. Accepted samples fill window positions 0, 1, 2, … in order.
- R4: A producer release is accepted only after exactly `WINDOW` samples have been written. An early release is ignored: the bank stays held and `in_ready` stays high.
- R5: A consumer acquire is granted only when the consumer's bank in turn has been released full by the producer. Otherwise the acquire is refused and `cons_held` stays low.
- R6: Banks alternate strictly. After reset both sides start on ping (bank 0), and each side moves to the other bank when its own release is accepted.
- R7: Reads use sample index i = `rd_addr`*16 + lane, with 16 lanes of 16 bits each (lane 0 in bits 15:0). Index i < `MARGIN` returns margin slot i. Index `MARGIN` ≤ i < `MARGIN+WINDOW` returns window sample i−`MARGIN`. Any larger index returns zero. `rd_data` is registered one cycle after `rd_en`.
- R8: Margin slot j holds sample `WINDOW-MARGIN+j` of the previous window. The margin of the first window after reset is zero.
- R9: A read issued while the consumer holds no bank returns zero.
- R10: A bank held by the consumer is never granted to the producer. The producer stalls with `in_ready` low until the consumer releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Producer sample valid |
| in_ready | output | 1 | Buffer can accept a sample |
| in_data | input | SAMPLE_W | Producer sample |
| prod_acquire | input | 1 | Producer requests its next bank |
| prod_release | input | 1 | Producer hands its full bank over |
| prod_held | output | 1 | Producer owns a bank |
| cons_acquire | input | 1 | Consumer requests its next bank |
| cons_release | input | 1 | Consumer frees its bank |
| cons_held | output | 1 | Consumer owns a bank |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Word address within margin plus window |
| rd_data | output | RD_W | Packed samples, lowest index in LSBs |

## Verification
The assertions take for granted that acquire and release inputs are single-cycle pulses and that `in_valid` is raised only while the producer owns a bank. The bench drives every strobe for exactly one clock. It streams a window only after the acquire has been observed as granted. It also probes refused and early requests deliberately, to show that the design ignores them and the invariants still hold.

// File: rtl/pwb_pkg.sv
// Package: shared types for the dual-bank window buffer.
// Assumes: exactly two banks; the bank index is one bit.
package pwb_pkg;
    typedef enum logic [1:0] {
        B_FREE = 2'd0,   // owned by nobody, waiting for the producer
        B_PROD = 2'd1,   // producer is filling it
        B_FULL = 2'd2,   // filled and released, waiting for the consumer
        B_CONS = 2'd3    // consumer is reading it
    } bank_state_t;
endpackage

// File: rtl/pwb_lock_ctrl.sv
// Module: pwb_lock_ctrl
// Keeps the per-bank ownership state, the producer and consumer turn pointers
// and the producer write count. It grants or refuses the acquire and release
// pulses of both sides.
// Assumes: acquire and release arrive as single-cycle pulses.
module pwb_lock_ctrl
    import pwb_pkg::*;
#(
    parameter int WINDOW = 32,
    localparam int CW = $clog2(WINDOW + 1),
    localparam int IW = $clog2(WINDOW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          p_acq,
    input  logic          p_rel,
    input  logic          c_acq,
    input  logic          c_rel,
    output logic          in_ready,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic          wr_bank,
    output logic          p_held,
    output logic          c_held,
    output logic          c_bank,
    output logic          p_grant
);
    bank_state_t   state_q [2];
    bank_state_t   state_d [2];
    logic          p_sel, c_sel;
    logic [CW-1:0] wcnt;
    logic          p_rel_ok, c_grant, c_rel_ok, c_turn_full;

    // Decode which requests are legal in the current ownership state
    always_comb begin
        p_held      = (state_q[p_sel] == B_PROD);
        c_held      = (state_q[c_sel] == B_CONS);
        c_turn_full = (state_q[c_sel] == B_FULL);
        p_grant     = p_acq && (state_q[p_sel] == B_FREE);
        p_rel_ok    = p_rel && p_held && (wcnt == CW'(WINDOW));
        c_grant     = c_acq && c_turn_full;
        c_rel_ok    = c_rel && c_held;
        in_ready    = p_held && (wcnt < CW'(WINDOW));
        wr_en       = in_valid && in_ready;
        wr_idx      = wcnt[IW-1:0];
        wr_bank     = p_sel;
        c_bank      = c_sel;
    end

    // Work out the next owner of each bank
    always_comb begin
        state_d = state_q;
        if (p_grant)  state_d[p_sel] = B_PROD;
        if (p_rel_ok) state_d[p_sel] = B_FULL;
        if (c_grant)  state_d[c_sel] = B_CONS;
        if (c_rel_ok) state_d[c_sel] = B_FREE;
    end

    // Register the bank states, turn pointers and write count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q[0] <= B_FREE;
            state_q[1] <= B_FREE;
            p_sel      <= 1'b0;
            c_sel      <= 1'b0;
            wcnt       <= '0;
        end else begin
            state_q <= state_d;
            if (p_rel_ok) begin
                p_sel <= ~p_sel;
                wcnt  <= '0;
            end else if (wr_en) begin
                wcnt  <= wcnt + 1'b1;
            end
            if (c_rel_ok) c_sel <= ~c_sel;
        end
    end

    // R3: no sample is taken beyond the end of the window
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wcnt < CW'(WINDOW)));
    // R4: the producer moves on only from a completely written bank
    a_r4_full_release: assert property (@(posedge clk) disable iff (!rst_n)
        (p_sel != $past(p_sel)) |-> ($past(wcnt) == CW'(WINDOW) && $past(p_held)));
    // R5: the consumer gains a bank only if it was released full
    a_r5_acquire_full: assert property (@(posedge clk) disable iff (!rst_n)
        (c_held && !$past(c_held)) |-> $past(c_turn_full));
    // R6: the consumer pointer flips only when it gives up a held bank
    a_r6_cons_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (c_sel != $past(c_sel)) |-> ($past(c_held) && !c_held));
endmodule

// File: rtl/pwb_tail.sv
// Module: pwb_tail
// Shift register that keeps the last MARGIN accepted samples. Slot 0 is the
// oldest of them and slot MARGIN-1 the newest. It starts at zero, so the
// first window gets an all-zero margin.
// Assumes: shift is asserted once for each accepted producer sample.
module pwb_tail #(
    parameter int SAMPLE_W = 16,
    parameter int MARGIN   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift,
    input  logic [SAMPLE_W-1:0]        din,
    output logic [MARGIN*SAMPLE_W-1:0] tail
);
    logic [MARGIN*SAMPLE_W-1:0] tail_d;

    // Pick the shifted vector; a one-slot margin just takes the new sample
    generate
        if (MARGIN == 1) begin : g_single
            always_comb tail_d = din;
        end else begin : g_multi
            always_comb tail_d = {din, tail[MARGIN*SAMPLE_W-1:SAMPLE_W]};
        end
    endgenerate

    // Register the tail of the sample stream
    always_ff @(posedge clk) begin
        if (!rst_n)     tail <= '0;
        else if (shift) tail <= tail_d;
    end
endmodule

// File: rtl/pwb_bank_store.sv
// Module: pwb_bank_store
// Holds the two window banks and their margin slots. It maps a word address
// onto margin plus window as one index range and returns a registered wide
// read word.
// Assumes: the margin of a bank is loaded only when the producer acquires it.
module pwb_bank_store #(
    parameter int SAMPLE_W = 16,
    parameter int WINDOW   = 32,
    parameter int MARGIN   = 3,
    parameter int RD_W     = 256,
    localparam int LANES   = RD_W / SAMPLE_W,
    localparam int DEPTH   = MARGIN + WINDOW,
    localparam int WORDS   = (DEPTH + LANES - 1) / LANES,
    localparam int AW      = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int IW      = $clog2(WINDOW),
    localparam int XW      = $clog2(WORDS * LANES) + 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       wr_bank,
    input  logic [IW-1:0]              wr_idx,
    input  logic [SAMPLE_W-1:0]        wr_data,
    input  logic                       mg_load,
    input  logic                       mg_bank,
    input  logic [MARGIN*SAMPLE_W-1:0] mg_vec,
    input  logic                       rd_en,
    input  logic                       rd_valid_bank,
    input  logic                       rd_bank,
    input  logic [AW-1:0]              rd_addr,
    output logic [RD_W-1:0]            rd_data
);
    logic [SAMPLE_W-1:0] mem [2][WINDOW];
    logic [SAMPLE_W-1:0] mg  [2][MARGIN];
    logic [RD_W-1:0]     word_c;

    // Store producer samples and capture margins on acquisition
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_bank][wr_idx] <= wr_data;
        if (mg_load) begin
            for (int j = 0; j < MARGIN; j++)
                mg[mg_bank][j] <= mg_vec[j*SAMPLE_W +: SAMPLE_W];
        end
    end

    // Assemble one lane of the read word from margin, window or zero fill
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [XW-1:0] idx;
            always_comb begin
                idx = XW'(rd_addr) * XW'(LANES) + XW'(l);
                if (idx < XW'(MARGIN))
                    word_c[l*SAMPLE_W +: SAMPLE_W] = mg[rd_bank][idx];
                else if (idx < XW'(DEPTH))
                    word_c[l*SAMPLE_W +: SAMPLE_W] = mem[rd_bank][IW'(idx - XW'(MARGIN))];
                else
                    word_c[l*SAMPLE_W +: SAMPLE_W] = '0;
            end
        end
    endgenerate

    // Register the read word; zero when the consumer holds nothing
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_valid_bank ? word_c : '0;
    end

    // R9: a read issued without a held bank produces zero
    a_r9_unheld_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_valid_bank) |=> (rd_data == '0));
endmodule

// File: rtl/pingpong_window_buf.sv
// Module: pingpong_window_buf (top)
// Dual-bank window buffer with a margin of overlap samples in front of every
// window, and per-bank locks on both sides.
// Assumes: TAPS >= 2, WINDOW >= MARGIN, and RD_W is a multiple of SAMPLE_W.
module pingpong_window_buf #(
    parameter int SAMPLE_W = 16,
    parameter int WINDOW   = 32,
    parameter int TAPS     = 4,
    parameter int RD_W     = 256,
    localparam int MARGIN  = TAPS - 1,
    localparam int LANES   = RD_W / SAMPLE_W,
    localparam int WORDS   = (MARGIN + WINDOW + LANES - 1) / LANES,
    localparam int AW      = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int IW      = $clog2(WINDOW)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic                prod_acquire,
    input  logic                prod_release,
    output logic                prod_held,
    input  logic                cons_acquire,
    input  logic                cons_release,
    output logic                cons_held,
    input  logic                rd_en,
    input  logic [AW-1:0]       rd_addr,
    output logic [RD_W-1:0]     rd_data
);
    logic                       wr_en, wr_bank, c_bank, p_grant;
    logic [IW-1:0]              wr_idx;
    logic [MARGIN*SAMPLE_W-1:0] tail;

    pwb_lock_ctrl #(.WINDOW(WINDOW)) u_lock (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .p_acq(prod_acquire), .p_rel(prod_release),
        .c_acq(cons_acquire), .c_rel(cons_release),
        .in_ready(in_ready), .wr_en(wr_en), .wr_idx(wr_idx), .wr_bank(wr_bank),
        .p_held(prod_held), .c_held(cons_held), .c_bank(c_bank), .p_grant(p_grant)
    );

    pwb_tail #(.SAMPLE_W(SAMPLE_W), .MARGIN(MARGIN)) u_tail (
        .clk(clk), .rst_n(rst_n), .shift(wr_en), .din(in_data), .tail(tail)
    );

    pwb_bank_store #(.SAMPLE_W(SAMPLE_W), .WINDOW(WINDOW), .MARGIN(MARGIN),
                     .RD_W(RD_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_data(in_data),
        .mg_load(p_grant), .mg_bank(wr_bank), .mg_vec(tail),
        .rd_en(rd_en), .rd_valid_bank(cons_held), .rd_bank(c_bank),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // R10: producer and consumer never own the same bank at once
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(prod_held && cons_held && (wr_bank == c_bank)));
    // R2: the producer gains ownership only through a granted acquire
    a_r2_grant_only: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_held && !$past(prod_held)) |-> $past(prod_acquire));
endmodule

// File: tb/pingpong_window_buf_test.sv
// Directed bench for pingpong_window_buf. Each scenario is a task that checks
// its own results against a model computed from the requirements.
module pingpong_window_buf_test;
    localparam int SW = 16, WIN = 32, TAPS = 4, RW = 256;
    localparam int M = TAPS - 1, LANES = RW / SW, WORDS = (M + WIN + LANES - 1) / LANES;
    localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, prod_acquire = 0, prod_release = 0;
    logic cons_acquire = 0, cons_release = 0, rd_en = 0;
    logic [SW-1:0] in_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic in_ready, prod_held, cons_held;
    logic [RW-1:0] rd_data;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pingpong_window_buf #(.SAMPLE_W(SW), .WINDOW(WIN), .TAPS(TAPS), .RD_W(RW)) uut (.*);

    function automatic logic [SW-1:0] val(int n, int k);
        return SW'(n * 256 + k + 1);
    endfunction

    // Expected sample at index i of the read range for window n (R7, R8)
    function automatic logic [SW-1:0] exp_s(int n, int i);
        if (i < M) return (n == 0) ? '0 : val(n - 1, WIN - M + i);
        if (i < M + WIN) return val(n, i - M);
        return '0;
    endfunction

    task automatic chk(bit ok, string req, logic [RW-1:0] act, logic [RW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk) s = 1;
        @(negedge clk) s = 0;
    endtask

    task automatic rd_word(int a, output logic [RW-1:0] w);
        @(negedge clk) begin rd_en = 1; rd_addr = AW'(a); end
        @(negedge clk) begin rd_en = 0; w = rd_data; end
    endtask

    task automatic t_reset;
        chk(!in_ready && !prod_held && !cons_held, "R1 idle flags", {prod_held, cons_held, in_ready}, 0);
        chk(rd_data == '0, "R1 rd_data", rd_data, 0);
    endtask

    task automatic t_early_consumer;
        pulse(cons_acquire);
        chk(!cons_held, "R5 refused before fill", cons_held, 0);
    endtask

    // Acquire, stream window n (probing an early release), and release it
    task automatic t_fill(int n);
        pulse(prod_acquire);
        chk(prod_held && in_ready, "R2 producer grant", {prod_held, in_ready}, 2'b11);
        for (int k = 0; k < WIN; k++) begin
            @(negedge clk) begin in_valid = 1; in_data = val(n, k); end
            if (k == WIN - 2) prod_release = 1;
            @(posedge clk);
            #1 prod_release = 0;
        end
        @(negedge clk) in_valid = 0;
        chk(prod_held, "R4 early release ignored", prod_held, 1);
        chk(!in_ready, "R3 ready low when full", in_ready, 0);
        pulse(prod_release);
        chk(!prod_held && !in_ready, "R4 release accepted", {prod_held, in_ready}, 0);
    endtask

    task automatic t_read(int n);
        logic [RW-1:0] w, e;
        for (int a = 0; a < WORDS; a++) begin
            rd_word(a, w);
            for (int l = 0; l < LANES; l++) e[l*SW +: SW] = exp_s(n, a * LANES + l);
            chk(w == e, (n == 0) ? "R8 zero margin / R7 map" : "R8 margin / R7 map", w, e);
        end
    endtask

    task automatic t_stall;
        pulse(prod_acquire);
        chk(!prod_held && !in_ready, "R10 bank held by consumer not granted", {prod_held, in_ready}, 0);
    endtask

    task automatic t_unheld_read;
        logic [RW-1:0] w;
        rd_word(0, w);
        chk(w == '0, "R9 read without bank", w, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_early_consumer();
        t_fill(0);
        pulse(cons_acquire);
        chk(cons_held, "R5 R6 consumer gets ping", cons_held, 1);
        t_read(0);
        t_fill(1);
        t_stall();
        pulse(cons_release);
        chk(!cons_held, "R6 consumer release", cons_held, 0);
        t_unheld_read();
        t_fill(2);
        pulse(cons_acquire);
        chk(cons_held, "R6 consumer gets pong", cons_held, 1);
        t_read(1);
        pulse(cons_release);
        pulse(cons_acquire);
        chk(cons_held, "R6 consumer back on ping", cons_held, 1);
        t_read(2);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule